// File: doc/BRIEF.md
# Key-Sequence Watchdog Timer with Service Window

This block is a supervision timer. It counts clock cycles through a period picked by a 3-bit rate code. If software does not service it within that period, it raises a reset request for the system's reset controller. Servicing means writing two key bytes, 0x55 and then 0xAA, to a single 8-bit arm register on a simple register bus that has a write strobe, an address and write data. Writing any other byte while the timer runs is treated as a software fault and requests a reset at once.

An optional window mode allows servicing only near the end of the period. Any arm-register write made before the final quarter of the period is treated as a fault. Each reset request is a one-cycle pulse. A 2-bit cause output records why the last request was raised. After a request, the timer and the key sequence start again from zero.

Top module: `key_seq_watchdog`

## Requirements
- R1: When `rate_sel` is 0 the timer is off. No reset request is raised, and writes to the arm register change nothing.
- R2: `bus_rdata` always reads 0x00.
- R3: For `rate_sel` = c (1 to 7) the period is P = 2^(BASE_LOG2 + STEP_LOG2·c) cycles, which is 2^(8+2c) by default. If no service occurs, `wd_rst_req` is high in the P-th cycle after the clock edge that restarted the count, and `wd_cause` = 2'b01 (time-out).
- R4: Writes whose `bus_addr` differs from `ARM_ADDR` have no effect.
- R5: While enabled, writing a byte other than 0x55 or 0xAA to the arm register raises `wd_rst_req` in the next cycle, with `wd_cause` = 2'b10 (bad key).
- R6: Writing 0xAA after a 0x55 restarts the period at the 0xAA write. Other cycles may separate the two writes, and repeated 0x55 writes keep the sequence armed.
- R7: A 0xAA write that no 0x55 has armed is ignored. It neither restarts the period nor raises a request.
- R8: With `win_en` = 1, any arm write made while the count is below 3P/4 raises a request with `wd_cause` = 2'b11 (early write). This code takes priority over the bad-key code. Writes at a count of 3P/4 or more are handled as in R5 to R7.
- R9: The request lasts one cycle. `wd_cause` holds its value until the next request. A request clears the count and the armed state.
- R10: Changing `rate_sel` from 0 to a nonzero code starts a fresh period with the armed state cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_sel | input | 3 | Period code; 0 turns the timer off |
| win_en | input | 1 | Window mode enable |
| bus_wr | input | 1 | Register bus write strobe |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Arm register read data, always zero |
| wd_rst_req | output | 1 | One-cycle reset request |
| wd_cause | output | 2 | Cause of the last request: 00 none, 01 time-out, 10 bad key, 11 early write |

## Verification
The in-line properties check several things on every cycle. The timer stays silent while off. The count steps by one unless it is cleared. A completed key pair zeroes the count. Bad-key and early writes are followed by a request carrying the matching cause code. Every time-out leads to a request. The bench scenarios cover what needs a history of bus traffic: the exact cycle of each time-out, an unarmed 0xAA being ignored, the armed state being lost across a request or a disable, the exact 3P/4 window edge, and address filtering.

// File: rtl/wd_pkg.sv
package wd_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_TMO   = 2'b01,
    CAUSE_KEY   = 2'b10,
    CAUSE_EARLY = 2'b11
  } wd_cause_e;

  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;

  // log2 of the period for a rate code
  function automatic int wd_log2(input int base, input int step, input logic [2:0] code);
    return base + step * int'(code);
  endfunction

  // last count value of a period of 2^lg cycles
  function automatic logic [31:0] wd_last(input int lg);
    return (32'd1 << lg) - 32'd1;
  endfunction

  // first count value inside the service window (3/4 of the period)
  function automatic logic [31:0] wd_wstart(input int lg);
    return (32'd1 << lg) - (32'd1 << (lg - 2));
  endfunction

endpackage

// File: rtl/wd_counter.sv
module wd_counter
  import wd_pkg::*;
#(
  parameter int BASE_LOG2 = 8,
  parameter int STEP_LOG2 = 2,
  parameter int CW        = BASE_LOG2 + STEP_LOG2 * 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  logic [2:0]    rate,
  output logic [CW-1:0] cnt,
  output logic          at_end,
  output logic          win_open
);

  logic [31:0] cnt32;
  logic [31:0] last32;
  logic [31:0] wstart32;
  int          lg;

  always_comb begin
    lg       = wd_log2(BASE_LOG2, STEP_LOG2, rate);
    last32   = wd_last(lg);
    wstart32 = wd_wstart(lg);
    cnt32    = {{(32-CW){1'b0}}, cnt};
  end

  assign at_end   = (cnt32 >= last32);
  assign win_open = (cnt32 >= wstart32);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en || clr) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/wd_keyseq.sv
module wd_keyseq
  import wd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       clr,
  input  logic       wr_hit,
  input  logic [7:0] wdata,
  input  logic       win_en,
  input  logic       win_open,
  output logic       armed,
  output logic       service,
  output logic       bad_key,
  output logic       early
);

  logic is_arm, is_fire;

  assign is_arm  = (wdata == KEY_ARM);
  assign is_fire = (wdata == KEY_FIRE);

  assign early   = wr_hit && win_en && !win_open;
  assign bad_key = wr_hit && !early && !is_arm && !is_fire;
  assign service = wr_hit && !early && is_fire && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          armed <= 1'b0;
    else if (!en || clr)                 armed <= 1'b0;
    else if (wr_hit && !early && is_arm) armed <= 1'b1;
  end

endmodule

// File: rtl/wd_resetgen.sv
module wd_resetgen
  import wd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tmo,
  input  logic      bad_key,
  input  logic      early,
  output logic      fire,
  output logic      req,
  output wd_cause_e cause
);

  wd_cause_e next_cause;

  always_comb begin
    if (early)        next_cause = CAUSE_EARLY;
    else if (bad_key) next_cause = CAUSE_KEY;
    else              next_cause = CAUSE_TMO;
  end

  assign fire = tmo || bad_key || early;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req   <= 1'b0;
      cause <= CAUSE_NONE;
    end else begin
      req <= fire;
      if (fire) cause <= next_cause;
    end
  end

endmodule

// File: rtl/key_seq_watchdog.sv
module key_seq_watchdog
  import wd_pkg::*;
#(
  parameter int               BASE_LOG2 = 8,
  parameter int               STEP_LOG2 = 2,
  parameter int               ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] ARM_ADDR = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        rate_sel,
  input  logic              win_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              wd_rst_req,
  output logic [1:0]        wd_cause
);

  localparam int CW = BASE_LOG2 + STEP_LOG2 * 7;

  logic          en, en_rise, was_off;
  logic          wr_hit, clr;
  logic [CW-1:0] cnt;
  logic          at_end, win_open;
  logic          armed, service, bad_key, early;
  logic          tmo, fire;
  wd_cause_e     cause;

  assign en      = (rate_sel != 3'd0);
  assign en_rise = en && was_off;
  assign wr_hit  = en && bus_wr && (bus_addr == ARM_ADDR);
  assign tmo     = en && at_end && !service;
  assign clr     = fire || service || en_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) was_off <= 1'b1;
    else        was_off <= !en;
  end

  wd_counter #(.BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2), .CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .rate(rate_sel),
    .cnt(cnt), .at_end(at_end), .win_open(win_open)
  );

  wd_keyseq u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .wr_hit(wr_hit),
    .wdata(bus_wdata), .win_en(win_en), .win_open(win_open),
    .armed(armed), .service(service), .bad_key(bad_key), .early(early)
  );

  wd_resetgen u_rst (
    .clk(clk), .rst_n(rst_n), .tmo(tmo), .bad_key(bad_key), .early(early),
    .fire(fire), .req(wd_rst_req), .cause(cause)
  );

  assign wd_cause  = cause;
  assign bus_rdata = 8'h00;

  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !wd_rst_req);

  a_r5_badkey_fires: assert property (@(posedge clk) disable iff (!rst_n)
    bad_key |=> (wd_rst_req && wd_cause == CAUSE_KEY));

  a_r8_early_fires: assert property (@(posedge clk) disable iff (!rst_n)
    early |=> (wd_rst_req && wd_cause == CAUSE_EARLY));

  a_r6_service_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    service |=> (cnt == '0 && !armed));

  a_r3_timeout_fires: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> wd_rst_req);

  a_r9_cause_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_req |-> (wd_cause != CAUSE_NONE));

endmodule

// File: tb/tb_key_seq_watchdog.sv
module tb_key_seq_watchdog;

  localparam logic [7:0] ARM = 8'h20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] rate_sel = 3'd0;
  logic       win_en = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       wd_rst_req;
  logic [1:0] wd_cause;

  int cyc = 0;
  int checks = 0;
  int fails = 0;

  typedef struct { int at; logic [1:0] cause; string req; } exp_t;
  exp_t q[$];

  key_seq_watchdog #(.ARM_ADDR(ARM)) dut (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .win_en(win_en),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wd_rst_req(wd_rst_req), .wd_cause(wd_cause)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int period(input int code);
    return 1 << (8 + 2 * code);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expect_req(input int at, input logic [1:0] c, input string req);
    exp_t e;
    e.at = at; e.cause = c; e.req = req;
    q.push_back(e);
  endtask

  // monitor: compares every request pulse against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (q.size() > 0 && q[0].at < cyc) begin
        check(1'b0, {q[0].req, " missed request"}, 0, q[0].at);
        void'(q.pop_front());
      end
      if (wd_rst_req) begin
        if (q.size() == 0) check(1'b0, "unexpected request", cyc, 0);
        else begin
          check(q[0].at == cyc, {q[0].req, " request cycle"}, cyc, q[0].at);
          check(wd_cause == q[0].cause, {q[0].req, " cause"}, wd_cause, q[0].cause);
          void'(q.pop_front());
        end
      end
    end
  end

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, output int e);
    @(negedge clk);
    e = cyc + 1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic set_rate(input logic [2:0] r, output int z);
    @(negedge clk);
    z = cyc + 1;
    rate_sel = r;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int z, e, p1, wst;
    p1 = period(1);
    wst = p1 - p1 / 4;
    repeat (3) @(negedge clk);
    check(wd_rst_req == 1'b0, "reset req", wd_rst_req, 0);
    check(wd_cause == 2'b00, "reset cause", wd_cause, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: off, bad byte ignored, no time-out
    wr(ARM, 8'h12, e);
    wait_to(cyc + 1100);
    check(wd_cause == 2'b00, "R1 cause unchanged", wd_cause, 0);

    // R10 fresh start, R4 other address, R6 service with gap
    set_rate(3'd1, z);
    wr(ARM + 8'h1, 8'h12, e);
    wr(ARM, 8'h55, e);
    wait_to(cyc + 5);
    wr(ARM, 8'hAA, z);
    check(bus_rdata == 8'h00, "R2 rdata", bus_rdata, 0);
    // R6 repeated arm keys
    wr(ARM, 8'h55, e);
    wr(ARM, 8'h55, e);
    wait_to(cyc + 3);
    wr(ARM, 8'hAA, z);
    check(bus_rdata == 8'h00, "R2 rdata after keys", bus_rdata, 0);

    // R7: unarmed AA ignored, R3 time-out at z+P
    wr(ARM, 8'hAA, e);
    expect_req(z + p1, 2'b01, "R7/R3");
    wait_to(z + p1 + 1);
    z = z + p1;

    // R9: armed state lost across a request
    wr(ARM, 8'h55, e);
    expect_req(z + p1, 2'b01, "R9 tmo");
    wait_to(z + p1 + 1);
    z = z + p1;
    wr(ARM, 8'hAA, e);
    expect_req(z + p1, 2'b01, "R9 arm cleared");
    wait_to(z + p1 + 1);
    z = z + p1;
    check(wd_cause == 2'b01, "R9 cause held", wd_cause, 1);

    // R5: bad key, single-cycle pulse
    wr(ARM, 8'h3C, e);
    expect_req(e, 2'b10, "R5");
    z = e;
    wait_to(e + 1);
    check(wd_rst_req == 1'b0, "R9 one-cycle pulse", wd_rst_req, 0);

    // R10: disable clears armed state
    wr(ARM, 8'h55, e);
    set_rate(3'd0, e);
    wait_to(cyc + 3);
    set_rate(3'd1, z);
    wr(ARM, 8'hAA, e);
    expect_req(z + p1, 2'b01, "R10");
    wait_to(z + p1 + 1);
    z = z + p1;

    // R8: window mode
    win_en = 1'b1;
    wait_to(z + 10);
    wr(ARM, 8'h55, e);
    expect_req(e, 2'b11, "R8 early key");
    z = e;
    wait_to(z + 5);
    wr(ARM, 8'h12, e);
    expect_req(e, 2'b11, "R8 early over bad key");
    z = e;
    wait_to(z + 1 + (wst - 1) - 2);
    wr(ARM, 8'h55, e);
    expect_req(e, 2'b11, "R8 last closed count");
    check(e - z - 1 == wst - 1, "R8 placement", e - z - 1, wst - 1);
    z = e;
    wait_to(z + 1 + wst - 2);
    wr(ARM, 8'h55, e);
    check(e - z - 1 == wst, "R8 placement open", e - z - 1, wst);
    wr(ARM, 8'hAA, z);
    expect_req(z + p1, 2'b01, "R8 serviced in window");
    wait_to(z + p1 + 1);
    z = z + p1;

    // R3: longer period for rate code 2
    win_en = 1'b0;
    set_rate(3'd0, e);
    set_rate(3'd2, z);
    expect_req(z + period(2), 2'b01, "R3 rate2");
    wait_to(z + period(2) + 2);

    check(q.size() == 0, "scoreboard drained", q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule